// File: doc/BRIEF.md
# Data-Processing ALU with Shifter Operand

This block performs the sixteen classic data-processing operations of a 32-bit load/store processor: four logical operations (AND, EOR, ORR, BIC), two moves (MOV, MVN), six arithmetic operations (ADD, ADC, SUB, SBC, RSB, RSC) and four compare/test forms (TST, TEQ, CMP, CMN). Operand 1 always comes from the caller. Operand 2 comes from one of two sources. The first is an 8-bit constant rotated right by an even amount taken from a 4-bit field. The second is a value the barrel shifter has already produced, together with the carry that shift generated.

One operation is accepted in each cycle in which `issue_i` is high. Its result, the destination write enable, the flag write enable and the new N, Z, C and V values appear on registered outputs one clock later. Logical operations take their C from the carry produced while operand 2 was formed, and keep V as it was. Arithmetic operations take C from the adder carry-out and V from the signed overflow. When flags are requested but the destination is the program counter, the flag write is withheld so the surrounding core can apply its own status handling. Register-file access, condition evaluation and the program-counter write itself belong to the surrounding pipeline.

Top module: `dp_alu`

## Requirements
- R1: After reset, `wr_en_o`, `flags_we_o` and `result_o` are all 0.
- R2: With `imm_sel_i`=1, operand 2 is `imm8_i` zero-extended and rotated right by 2×`rot_i`. With `imm_sel_i`=0, operand 2 is `shreg_val_i`.
- R3: The operand-2 carry is `shreg_carry_i` when `imm_sel_i`=0. For an immediate it is `c_flag_i` when `rot_i`=0, and otherwise bit 31 of the rotated value. Logical opcodes (0,1,8,9,12,13,14,15) output this carry as C.
- R4: The opcode encoding is 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. The arithmetic results are: ADD/CMN a+b; ADC a+b+C; SUB/CMP a−b; SBC a−b−(1−C); RSB b−a; RSC b−a−(1−C). All arithmetic is modulo 2^32, with a = operand 1 and b = operand 2.
- R5: The logical results are: AND/TST a&b; EOR/TEQ a^b; ORR a|b; MOV b; BIC a&~b; MVN ~b.
- R6: For arithmetic opcodes, C is the unsigned carry-out, which for the subtracting forms is "no borrow". V is the two's-complement overflow of the signed operation.
- R7: For logical opcodes, V equals the incoming `v_flag_i`.
- R8: N is bit 31 of `result_o`. Z is 1 exactly when `result_o` is 0.
- R9: Opcodes 8–11 never assert `wr_en_o`. Their computed value still appears on `result_o`. Every other issued opcode asserts `wr_en_o`.
- R10: `flags_we_o` = `set_flags_i` AND NOT `dest_pc_i` for an issued operation. With `dest_pc_i`=1 the destination write is unaffected.
- R11: Outputs update one cycle after an issue. A cycle without an issue gives `wr_en_o`=0 and `flags_we_o`=0, and `result_o` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Operation present this cycle |
| opcode_i | input | 4 | Operation code (see R4) |
| op1_i | input | 32 | Operand 1 |
| imm_sel_i | input | 1 | 1: operand 2 is the rotated immediate |
| imm8_i | input | 8 | Immediate constant |
| rot_i | input | 4 | Half of the rotate-right amount |
| shreg_val_i | input | 32 | Shifted register value from the barrel shifter |
| shreg_carry_i | input | 1 | Carry produced by the barrel shifter |
| c_flag_i | input | 1 | Current C flag |
| v_flag_i | input | 1 | Current V flag |
| set_flags_i | input | 1 | Request a flag update |
| dest_pc_i | input | 1 | Destination is the program counter |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Destination write enable |
| flags_we_o | output | 1 | Flag write enable |
| n_o | output | 1 | New N flag |
| z_o | output | 1 | New Z flag |
| c_o | output | 1 | New C flag |
| v_o | output | 1 | New V flag |

## Verification
Two functions can fall in the same cycle. The flag update for a logical operation must take the carry of the operand-2 rotation, not the stored C flag. The program-counter suppression must withhold that very flag update while leaving the destination write in place. The bench provokes the first by driving `c_flag_i` opposite to the rotation's bit 31 across every rotate amount. It provokes the second by issuing flag-setting operations with `dest_pc_i` high. In both cases it checks C, `flags_we_o` and `wr_en_o` together against values computed arithmetically, in the sample following the issue edge.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } dp_op_e;

    function automatic logic op_is_test(input logic [3:0] op);
        return (op[3:2] == 2'b10);
    endfunction

    function automatic logic op_is_logic(input logic [3:0] op);
        case (op)
            OP_AND, OP_EOR, OP_TST, OP_TEQ,
            OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dpa_opnd2.sv
module dpa_opnd2 #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic              imm_sel_i,
    input  logic [IMM_W-1:0]  imm8_i,
    input  logic [ROT_W-1:0]  rot_i,
    input  logic [DATA_W-1:0] shreg_val_i,
    input  logic              shreg_carry_i,
    input  logic              c_flag_i,
    output logic [DATA_W-1:0] op2_o,
    output logic              carry_o
);
    localparam int SH_W = ROT_W + 1;

    logic [DATA_W-1:0]   imm_ext;
    logic [2*DATA_W-1:0] imm_dbl;
    logic [SH_W-1:0]     sh_amt;
    logic [DATA_W-1:0]   imm_rot;

    always_comb begin
        imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm8_i};
        sh_amt  = {rot_i, 1'b0};
        imm_dbl = {imm_ext, imm_ext} >> sh_amt;
        imm_rot = imm_dbl[DATA_W-1:0];
        if (imm_sel_i) begin
            op2_o   = imm_rot;
            carry_o = (rot_i == '0) ? c_flag_i : imm_rot[DATA_W-1];
        end else begin
            op2_o   = shreg_val_i;
            carry_o = shreg_carry_i;
        end
    end
endmodule

// File: rtl/dpa_arith.sv
module dpa_arith
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        opcode_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_in_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              c_out_o,
    output logic              v_out_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] x_a;
    logic [DATA_W-1:0] x_b;
    logic              cin;
    logic [DATA_W:0]   wide;

    always_comb begin
        x_a = a_i;
        x_b = b_i;
        cin = 1'b0;
        case (opcode_i)
            OP_SUB, OP_CMP: begin x_b = ~b_i; cin = 1'b1;   end
            OP_SBC:         begin x_b = ~b_i; cin = c_in_i; end
            OP_RSB:         begin x_a = b_i; x_b = ~a_i; cin = 1'b1;   end
            OP_RSC:         begin x_a = b_i; x_b = ~a_i; cin = c_in_i; end
            OP_ADC:         cin = c_in_i;
            default:        cin = 1'b0;
        endcase
        wide    = {1'b0, x_a} + {1'b0, x_b} + {{DATA_W{1'b0}}, cin};
        sum_o   = wide[DATA_W-1:0];
        c_out_o = wide[DATA_W];
        v_out_o = (x_a[MSB] == x_b[MSB]) && (wide[MSB] != x_a[MSB]);
    end
endmodule

// File: rtl/dpa_logic.sv
module dpa_logic
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        opcode_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    always_comb begin
        case (opcode_i)
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_MOV:         res_o = b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [3:0]        opcode_i,
    input  logic [DATA_W-1:0] op1_i,
    input  logic              imm_sel_i,
    input  logic [IMM_W-1:0]  imm8_i,
    input  logic [ROT_W-1:0]  rot_i,
    input  logic [DATA_W-1:0] shreg_val_i,
    input  logic              shreg_carry_i,
    input  logic              c_flag_i,
    input  logic              v_flag_i,
    input  logic              set_flags_i,
    input  logic              dest_pc_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic              flags_we_o,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o,
    output logic              v_o
);
    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              wr_en;
        logic              flags_we;
        logic              n;
        logic              z;
        logic              c;
        logic              v;
    } alu_state_t;

    alu_state_t st_d, st_q;

    logic [DATA_W-1:0] op2;
    logic              op2_carry;
    logic [DATA_W-1:0] arith_sum;
    logic              arith_c;
    logic              arith_v;
    logic [DATA_W-1:0] logic_res;

    dpa_opnd2 #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_opnd2 (
        .imm_sel_i    (imm_sel_i),
        .imm8_i       (imm8_i),
        .rot_i        (rot_i),
        .shreg_val_i  (shreg_val_i),
        .shreg_carry_i(shreg_carry_i),
        .c_flag_i     (c_flag_i),
        .op2_o        (op2),
        .carry_o      (op2_carry)
    );

    dpa_arith #(.DATA_W(DATA_W)) u_arith (
        .opcode_i(opcode_i),
        .a_i     (op1_i),
        .b_i     (op2),
        .c_in_i  (c_flag_i),
        .sum_o   (arith_sum),
        .c_out_o (arith_c),
        .v_out_o (arith_v)
    );

    dpa_logic #(.DATA_W(DATA_W)) u_logic (
        .opcode_i(opcode_i),
        .a_i     (op1_i),
        .b_i     (op2),
        .res_o   (logic_res)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wr_en    = 1'b0;
        st_d.flags_we = 1'b0;
        if (issue_i) begin
            if (op_is_logic(opcode_i)) begin
                st_d.result = logic_res;
                st_d.c      = op2_carry;
                st_d.v      = v_flag_i;
            end else begin
                st_d.result = arith_sum;
                st_d.c      = arith_c;
                st_d.v      = arith_v;
            end
            st_d.n        = st_d.result[MSB];
            st_d.z        = (st_d.result == '0);
            st_d.wr_en    = !op_is_test(opcode_i);
            st_d.flags_we = set_flags_i && !dest_pc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o   = st_q.result;
    assign wr_en_o    = st_q.wr_en;
    assign flags_we_o = st_q.flags_we;
    assign n_o        = st_q.n;
    assign z_o        = st_q.z;
    assign c_o        = st_q.c;
    assign v_o        = st_q.v;
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic [3:0]        opcode_i,
    input logic              v_flag_i,
    input logic              set_flags_i,
    input logic              dest_pc_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic              flags_we_o,
    input logic              n_o,
    input logic              z_o,
    input logic              v_o
);
    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_is_test(opcode_i)) |=> !wr_en_o); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!wr_en_o && !flags_we_o && $stable(result_o))); // R11

    AST_PC_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && dest_pc_i) |=> !flags_we_o); // R10

    AST_LOGIC_V_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_is_logic(opcode_i)) |=> (v_o == $past(v_flag_i))); // R7

    AST_NZ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we_o |-> ((n_o == result_o[DATA_W-1]) && (z_o == (result_o == '0)))); // R8

    AST_FLAGS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && set_flags_i && !dest_pc_i) |=> flags_we_o); // R10
endmodule

bind dp_alu dp_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .opcode_i   (opcode_i),
    .v_flag_i   (v_flag_i),
    .set_flags_i(set_flags_i),
    .dest_pc_i  (dest_pc_i),
    .result_o   (result_o),
    .wr_en_o    (wr_en_o),
    .flags_we_o (flags_we_o),
    .n_o        (n_o),
    .z_o        (z_o),
    .v_o        (v_o)
);

// File: tb/dp_alu_tb.sv
module dp_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [3:0]  opcode_i = '0;
    logic [31:0] op1_i = '0;
    logic        imm_sel_i = 1'b0;
    logic [7:0]  imm8_i = '0;
    logic [3:0]  rot_i = '0;
    logic [31:0] shreg_val_i = '0;
    logic        shreg_carry_i = 1'b0;
    logic        c_flag_i = 1'b0;
    logic        v_flag_i = 1'b0;
    logic        set_flags_i = 1'b0;
    logic        dest_pc_i = 1'b0;
    logic [31:0] result_o;
    logic        wr_en_o, flags_we_o, n_o, z_o, c_o, v_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    dp_alu u_dut (.*);

    localparam logic [31:0] PAT [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
        32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0001, 32'h0F0F_F0F0};

    logic [31:0] e_res;
    logic        e_c, e_v;

    task automatic ref_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic cin, input logic vin, input logic op2c);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint ci = longint'(cin);
        longint ss;
        ss = 0;
        e_c = op2c;
        e_v = vin;
        case (op)
            0, 8:  e_res = a & b;
            1, 9:  e_res = a ^ b;
            12:    e_res = a | b;
            13:    e_res = b;
            14:    e_res = a & ~b;
            15:    e_res = ~b;
            2, 10: begin e_res = a - b; ss = sa - sb; e_c = (ua >= ub); end
            3:     begin e_res = b - a; ss = sb - sa; e_c = (ub >= ua); end
            4, 11: begin e_res = a + b; ss = sa + sb; e_c = (ua + ub) > 64'hFFFF_FFFF; end
            5:     begin e_res = a + b + {31'b0, cin}; ss = sa + sb + ci;
                         e_c = (ua + ub + ci) > 64'hFFFF_FFFF; end
            6:     begin e_res = a - b - {31'b0, ~cin}; ss = sa - sb - (1 - ci);
                         e_c = (ua >= ub + 1 - ci); end
            default: begin e_res = b - a - {31'b0, ~cin}; ss = sb - sa - (1 - ci);
                         e_c = (ub >= ua + 1 - ci); end
        endcase
        if (!(op inside {0, 1, 8, 9, 12, 13, 14, 15}))
            e_v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, then sample at the next falling edge.
    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic isel,
                          input logic [7:0] i8, input logic [3:0] rt, input logic [31:0] sv,
                          input logic sc, input logic cin, input logic vin,
                          input logic s, input logic pc);
        logic [63:0] dbl;
        logic [31:0] b;
        logic        bc;
        logic        e_we;
        dbl = {24'b0, i8, 24'b0, i8} >> (2 * rt);
        b   = isel ? dbl[31:0] : sv;
        bc  = isel ? ((rt == 0) ? cin : b[31]) : sc;
        ref_op(op, a, b, cin, vin, bc);
        e_we = !(op inside {8, 9, 10, 11});
        issue_i = 1'b1; opcode_i = op; op1_i = a; imm_sel_i = isel; imm8_i = i8;
        rot_i = rt; shreg_val_i = sv; shreg_carry_i = sc; c_flag_i = cin;
        v_flag_i = vin; set_flags_i = s; dest_pc_i = pc;
        @(negedge clk);
        issue_i = 1'b0;
        check($sformatf("R2 R4 R5 result op=%0d", op), result_o, e_res);
        check($sformatf("R3 R6 C op=%0d", op), {31'b0, c_o}, {31'b0, e_c});
        check($sformatf("R6 R7 V op=%0d", op), {31'b0, v_o}, {31'b0, e_v});
        check($sformatf("R8 NZ op=%0d", op), {30'b0, n_o, z_o},
              {30'b0, e_res[31], (e_res == 0)});
        check($sformatf("R9 wr_en op=%0d", op), {31'b0, wr_en_o}, {31'b0, e_we});
        check($sformatf("R10 flags_we op=%0d", op), {31'b0, flags_we_o}, {31'b0, s & ~pc});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 result", result_o, 32'h0);
        check("R1 enables", {30'b0, wr_en_o, flags_we_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Register operand: all opcodes over operand patterns and flag inputs.
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int k = 0; k < 8; k++)
                        run_op(op[3:0], PAT[i], 1'b0, 8'h00, 4'h0, PAT[j],
                               k[0], k[1], k[2], 1'b1, 1'b0);

        // Immediate operand: every rotate amount, carry-in opposing the rotated bit 31.
        for (int op = 0; op < 16; op++)
            for (int rt = 0; rt < 16; rt++)
                for (int c = 0; c < 2; c++) begin
                    run_op(op[3:0], 32'hC3A5_5A3C, 1'b1, 8'hB1, rt[3:0], 32'h0,
                           1'b0, c[0], 1'b1, 1'b1, 1'b0);
                    run_op(op[3:0], 32'h0000_0001, 1'b1, 8'h7E, rt[3:0], 32'h0,
                           1'b1, c[0], 1'b0, 1'b1, 1'b0);
                end

        // Flag update targeted at the program counter, and no-flag requests.
        for (int op = 0; op < 16; op++) begin
            run_op(op[3:0], 32'h8000_0000, 1'b1, 8'h01, 4'h1, 32'h0, 1'b0, 1'b1, 1'b0,
                   1'b1, 1'b1);
            run_op(op[3:0], 32'h7FFF_FFFF, 1'b0, 8'h00, 4'h0, 32'h1, 1'b1, 1'b0, 1'b1,
                   1'b0, 1'b0);
        end

        // R11: idle cycle after an operation keeps the result and drops enables.
        run_op(4'd4, 32'h0000_1000, 1'b0, 8'h0, 4'h0, 32'h0000_0234, 1'b0, 1'b0, 1'b0,
               1'b1, 1'b0);
        shreg_val_i = 32'hDEAD_BEEF; opcode_i = 4'd13;
        @(negedge clk);
        check("R11 idle result hold", result_o, 32'h0000_1234);
        check("R11 idle enables", {30'b0, wr_en_o, flags_we_o}, 32'h0);
        @(negedge clk);
        check("R11 idle second cycle", result_o, 32'h0000_1234);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule